// File: doc/BRIEF.md
# SDRAM Power-Up and Refresh Sequencer

This block owns the SDRAM command bus from reset until the memory is usable, then keeps the memory refreshed. After reset it drives only no-operation commands for a programmable power-up delay. It then runs a fixed start-up order: precharge of all banks, a programmable number of auto-refresh commands, and finally a mode-register load. A ready flag rises once the mode-register delay has passed.

In normal operation an interval timer counts the average refresh period. Each expiry adds one owed refresh to a saturating count. While any refresh is owed and the sequencer is idle, it raises a request to the main memory controller. When the controller grants the bus, the sequencer issues a precharge-all if the controller reports an open bank, waits the precharge time, and then issues an auto-refresh. After that it holds the bus for the refresh cycle time. Refreshes can be deferred up to a limit. When the limit is reached, the request is marked urgent.

All gaps are given in clock cycles and must be at least 2. The defaults derive the power-up and interval lengths from a clock-frequency parameter (2230 cycles per refresh at 143 MHz, a few cycles under the 15.6 us average).

Top module: `sdram_upkeep`

## Requirements
- R1: While reset is held, the command is NOP, ready, request and urgent are low, and busy is high.
- R2: After reset is released, exactly PWRUP_CYC cycles of NOP are driven before the first other command.
- R3: Start-up issues precharge-all, then TRP_CYC cycles later the first of INIT_REFS auto-refreshes, each spaced TRC_CYC cycles apart. TRC_CYC cycles after the last auto-refresh comes a mode-register load whose address equals MODE_WORD with bank 0. Only NOP is driven in between.
- R4: Ready rises TMRD_CYC cycles after the mode-register load, stays high until reset, and busy falls in the same cycle.
- R5: Command encoding is {cs_n,ras_n,cas_n,we_n}: NOP 0111, precharge 0010, auto-refresh 0001, mode load 0000. Precharge-all drives address bit 10 high with all other address bits and the bank at 0. NOP and auto-refresh drive address and bank 0.
- R6: One refresh becomes owed every REFI_CYC cycles counted from the first ready cycle. The request is high exactly when the sequencer is idle and at least one refresh is owed.
- R7: While the request is high and grant is low, only NOP is driven and the request stays high. The refresh sequence begins in the cycle after a clock edge that samples both request and grant high.
- R8: At the grant edge an open-bank indication selects precharge-all, then auto-refresh TRP_CYC cycles later. With no open bank, the auto-refresh comes in the next cycle.
- R9: Busy stays high from the first command of a refresh until TRC_CYC cycles after its auto-refresh, with NOP between.
- R10: The owed count saturates at MAX_OWED. Urgent is high exactly when the request is high and MAX_OWED refreshes are owed. Each grant retires one owed refresh.
- R11: Grant while no refresh is owed has no effect: the command stays NOP and busy stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| grant_i | input | 1 | Bus grant from the main controller |
| bank_open_i | input | 1 | Any bank has an open row (sampled at the grant edge) |
| cmd_o | output | 4 | Command {cs_n,ras_n,cas_n,we_n} |
| addr_o | output | ROW_W | Address bus |
| ba_o | output | BANK_W | Bank address |
| ready_o | output | 1 | Start-up sequence complete |
| busy_o | output | 1 | Sequencer owns the command bus |
| req_o | output | 1 | Refresh request to the main controller |
| urgent_o | output | 1 | Deferral limit reached |

## Verification
The hardest state to reach is the saturated owed count with urgent set. It needs the grant withheld across more refresh intervals than the deferral limit, after start-up has finished. Only then can the backlog drain in back-to-back refresh sequences. The bench uses short timing parameters. It withholds grant for five intervals against a limit of three, then grants continuously while toggling the open-bank input, so both refresh forms appear inside the drain. A behavioural queue model predicts every command, address and flag on each cycle, including the saturation and the drain order.

// File: rtl/sdr_seq_pkg.sv
package sdr_seq_pkg;

    // {cs_n, ras_n, cas_n, we_n}
    typedef enum logic [3:0] {
        CMD_MRS = 4'b0000,
        CMD_REF = 4'b0001,
        CMD_PRE = 4'b0010,
        CMD_NOP = 4'b0111
    } sdr_cmd_e;

    typedef enum logic [3:0] {
        ST_PWRUP,
        ST_INIT_PRE,
        ST_INIT_TRP,
        ST_INIT_REF,
        ST_INIT_TRC,
        ST_INIT_MRS,
        ST_INIT_TMRD,
        ST_IDLE,
        ST_RF_PRE,
        ST_RF_TRP,
        ST_RF_REF,
        ST_RF_TRC
    } seq_state_e;

    function automatic int unsigned max2(input int unsigned a, input int unsigned b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/sdr_seq_timer.sv
module sdr_seq_timer #(
    parameter int unsigned W       = 8,
    parameter int unsigned RST_VAL = 0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         done
);
    logic [W-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt <= W'(RST_VAL);
        else if (load)
            cnt <= load_val;
        else if (cnt != '0)
            cnt <= cnt - 1'b1;
    end

    assign done = (cnt == '0);

endmodule

// File: rtl/sdr_seq_interval.sv
module sdr_seq_interval #(
    parameter int unsigned REFI_CYC = 2230,
    parameter int unsigned MAX_OWED = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic take,
    output logic owed_any,
    output logic owed_full
);
    localparam int unsigned CW = (REFI_CYC > 2) ? $clog2(REFI_CYC) : 1;
    localparam int unsigned OW = $clog2(MAX_OWED + 1);
    localparam logic [CW-1:0] RELOAD = CW'(REFI_CYC - 1);
    localparam logic [OW-1:0] LIMIT  = OW'(MAX_OWED);

    logic [CW-1:0] cnt;
    logic [OW-1:0] owed;
    logic          tick;

    assign tick = run && (cnt == '0);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt <= RELOAD;
        else if (run)
            cnt <= (cnt == '0) ? RELOAD : cnt - 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            owed <= '0;
        else begin
            unique case ({tick, take})
                2'b10:   if (owed != LIMIT) owed <= owed + 1'b1;
                2'b01:   owed <= owed - 1'b1;
                default: owed <= owed;
            endcase
        end
    end

    assign owed_any  = (owed != '0);
    assign owed_full = (owed == LIMIT);

endmodule

// File: rtl/sdram_upkeep.sv
module sdram_upkeep
    import sdr_seq_pkg::*;
#(
    parameter int unsigned CLK_MHZ     = 143,
    parameter int unsigned PWRUP_US    = 100,
    parameter int unsigned PWRUP_CYC   = CLK_MHZ * PWRUP_US,
    parameter int unsigned REFI_MARGIN = 4,
    parameter int unsigned REFI_CYC    = (CLK_MHZ * 15625) / 1000 - REFI_MARGIN,
    parameter int unsigned TRP_CYC     = 3,
    parameter int unsigned TRC_CYC     = 10,
    parameter int unsigned TMRD_CYC    = 2,
    parameter int unsigned INIT_REFS   = 8,
    parameter int unsigned MAX_OWED    = 8,
    parameter int unsigned ROW_W       = 12,
    parameter int unsigned BANK_W      = 2,
    parameter int unsigned AP_BIT      = 10,
    parameter logic [ROW_W-1:0] MODE_WORD = ROW_W'(12'h032)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              grant_i,
    input  logic              bank_open_i,
    output logic [3:0]        cmd_o,
    output logic [ROW_W-1:0]  addr_o,
    output logic [BANK_W-1:0] ba_o,
    output logic              ready_o,
    output logic              busy_o,
    output logic              req_o,
    output logic              urgent_o
);
    localparam int unsigned TMAX = max2(max2(PWRUP_CYC, TRC_CYC), max2(TRP_CYC, TMRD_CYC));
    localparam int unsigned TW   = $clog2(TMAX + 1);
    localparam int unsigned RW   = $clog2(INIT_REFS + 1);
    localparam logic [TW-1:0] LD_TRP  = TW'(TRP_CYC - 2);
    localparam logic [TW-1:0] LD_TRC  = TW'(TRC_CYC - 2);
    localparam logic [TW-1:0] LD_TMRD = TW'(TMRD_CYC - 2);
    localparam logic [RW-1:0] REFS_LAST = RW'(INIT_REFS);
    localparam logic [ROW_W-1:0] PRE_ALL_ADDR = ROW_W'(1) << AP_BIT;

    seq_state_e    state, nxt;
    logic [RW-1:0] ref_cnt;
    logic          ready_q;
    logic          t_load;
    logic [TW-1:0] t_val;
    logic          t_done;
    logic          take;
    logic          owed_any;
    logic          owed_full;

    sdr_seq_timer #(
        .W       (TW),
        .RST_VAL (PWRUP_CYC - 1)
    ) u_gap (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (t_load),
        .load_val (t_val),
        .done     (t_done)
    );

    sdr_seq_interval #(
        .REFI_CYC (REFI_CYC),
        .MAX_OWED (MAX_OWED)
    ) u_refi (
        .clk       (clk),
        .rst_n     (rst_n),
        .run       (ready_q),
        .take      (take),
        .owed_any  (owed_any),
        .owed_full (owed_full)
    );

    // State register and the few counters that follow it
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state   <= ST_PWRUP;
            ref_cnt <= '0;
            ready_q <= 1'b0;
        end else begin
            state <= nxt;
            if (state == ST_INIT_REF)
                ref_cnt <= ref_cnt + 1'b1;
            if (state == ST_INIT_TMRD && t_done)
                ready_q <= 1'b1;
        end
    end

    // Next state, timer loads and refresh retirement
    always_comb begin
        nxt    = state;
        t_load = 1'b0;
        t_val  = '0;
        take   = 1'b0;
        unique case (state)
            ST_PWRUP:     if (t_done) nxt = ST_INIT_PRE;
            ST_INIT_PRE: begin
                t_load = 1'b1;
                t_val  = LD_TRP;
                nxt    = ST_INIT_TRP;
            end
            ST_INIT_TRP:  if (t_done) nxt = ST_INIT_REF;
            ST_INIT_REF: begin
                t_load = 1'b1;
                t_val  = LD_TRC;
                nxt    = ST_INIT_TRC;
            end
            ST_INIT_TRC: begin
                if (t_done)
                    nxt = (ref_cnt == REFS_LAST) ? ST_INIT_MRS : ST_INIT_REF;
            end
            ST_INIT_MRS: begin
                t_load = 1'b1;
                t_val  = LD_TMRD;
                nxt    = ST_INIT_TMRD;
            end
            ST_INIT_TMRD: if (t_done) nxt = ST_IDLE;
            ST_IDLE: begin
                if (owed_any && grant_i) begin
                    take = 1'b1;
                    nxt  = bank_open_i ? ST_RF_PRE : ST_RF_REF;
                end
            end
            ST_RF_PRE: begin
                t_load = 1'b1;
                t_val  = LD_TRP;
                nxt    = ST_RF_TRP;
            end
            ST_RF_TRP:    if (t_done) nxt = ST_RF_REF;
            ST_RF_REF: begin
                t_load = 1'b1;
                t_val  = LD_TRC;
                nxt    = ST_RF_TRC;
            end
            ST_RF_TRC:    if (t_done) nxt = ST_IDLE;
            default:      nxt = ST_PWRUP;
        endcase
    end

    // Outputs decoded from the state
    always_comb begin
        cmd_o  = CMD_NOP;
        addr_o = '0;
        ba_o   = '0;
        unique case (state)
            ST_INIT_PRE, ST_RF_PRE: begin
                cmd_o  = CMD_PRE;
                addr_o = PRE_ALL_ADDR;
            end
            ST_INIT_REF, ST_RF_REF: cmd_o = CMD_REF;
            ST_INIT_MRS: begin
                cmd_o  = CMD_MRS;
                addr_o = MODE_WORD;
            end
            default: cmd_o = CMD_NOP;
        endcase
        ready_o  = ready_q;
        busy_o   = (state != ST_IDLE);
        req_o    = (state == ST_IDLE) && owed_any;
        urgent_o = (state == ST_IDLE) && owed_any && owed_full;
    end

endmodule

// File: rtl/sdram_upkeep_chk.sv
module sdram_upkeep_chk #(
    parameter int unsigned TRP_CYC = 3,
    parameter int unsigned TRC_CYC = 10
) (
    input logic       clk,
    input logic       rst_n,
    input logic       grant_i,
    input logic [3:0] cmd_o,
    input logic       addr_ap,
    input logic       ready_o,
    input logic       busy_o,
    input logic       req_o,
    input logic       urgent_o
);
    localparam logic [3:0] C_NOP = 4'b0111;
    localparam logic [3:0] C_PRE = 4'b0010;
    localparam logic [3:0] C_REF = 4'b0001;

    logic [9:0] gap;
    logic [3:0] last_cmd;
    logic       have_last;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            gap       <= '0;
            last_cmd  <= C_NOP;
            have_last <= 1'b0;
        end else if (cmd_o != C_NOP) begin
            gap       <= '0;
            last_cmd  <= cmd_o;
            have_last <= 1'b1;
        end else if (gap != 10'h3ff) begin
            gap <= gap + 1'b1;
        end
    end

    // R3 / R8: nothing follows a precharge before the precharge time
    p_trp_gap_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_o != C_NOP && have_last && last_cmd == C_PRE) |-> (int'(gap) >= int'(TRP_CYC) - 1));

    // R9: nothing follows an auto-refresh before the cycle time
    p_trc_gap_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_o != C_NOP && have_last && last_cmd == C_REF) |-> (int'(gap) >= int'(TRC_CYC) - 1));

    // R5: every precharge closes all banks
    p_pre_all_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_o == C_PRE) |-> addr_ap);

    // R4: ready never drops
    p_ready_sticky_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ready_o |=> ready_o);

    // R6: a request only when ready and idle
    p_req_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
        req_o |-> (ready_o && !busy_o));

    // R10: urgent is a qualified request
    p_urgent_req_r10: assert property (@(posedge clk) disable iff (!rst_n)
        urgent_o |-> req_o);

    // R7: a granted request starts a command next cycle
    p_grant_start_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (req_o && grant_i) |=> (busy_o && cmd_o != C_NOP));

    // R11: idle bus carries only NOP
    p_quiet_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (ready_o && !busy_o) |-> (cmd_o == C_NOP));

endmodule

bind sdram_upkeep sdram_upkeep_chk #(
    .TRP_CYC (TRP_CYC),
    .TRC_CYC (TRC_CYC)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .grant_i  (grant_i),
    .cmd_o    (cmd_o),
    .addr_ap  (addr_o[AP_BIT]),
    .ready_o  (ready_o),
    .busy_o   (busy_o),
    .req_o    (req_o),
    .urgent_o (urgent_o)
);

// File: tb/sdram_upkeep_bench.sv
module sdram_upkeep_bench;

    localparam int PWRUP = 20;
    localparam int REFI  = 40;
    localparam int TRP   = 3;
    localparam int TRC   = 6;
    localparam int TMRD  = 2;
    localparam int NREF  = 8;
    localparam int MAXO  = 3;
    localparam logic [11:0] MODE = 12'h032;

    localparam logic [3:0] K_NOP = 4'b0111;
    localparam logic [3:0] K_PRE = 4'b0010;
    localparam logic [3:0] K_REF = 4'b0001;
    localparam logic [3:0] K_MRS = 4'b0000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        grant_i = 1'b0;
    logic        bank_open_i = 1'b0;
    logic [3:0]  cmd_o;
    logic [11:0] addr_o;
    logic [1:0]  ba_o;
    logic        ready_o, busy_o, req_o, urgent_o;

    always #10 clk = ~clk;

    sdram_upkeep #(
        .PWRUP_CYC (PWRUP),
        .REFI_CYC  (REFI),
        .TRP_CYC   (TRP),
        .TRC_CYC   (TRC),
        .TMRD_CYC  (TMRD),
        .INIT_REFS (NREF),
        .MAX_OWED  (MAXO),
        .MODE_WORD (MODE)
    ) u_sdram_upkeep (
        .clk         (clk),
        .rst_n       (rst_n),
        .grant_i     (grant_i),
        .bank_open_i (bank_open_i),
        .cmd_o       (cmd_o),
        .addr_o      (addr_o),
        .ba_o        (ba_o),
        .ready_o     (ready_o),
        .busy_o      (busy_o),
        .req_o       (req_o),
        .urgent_o    (urgent_o)
    );

    typedef struct {
        logic [3:0]  cmd;
        logic [11:0] addr;
        string       tag;
    } slot_t;

    slot_t q[$];
    int    owed = 0;
    int    since = 0;
    bit    rdy = 0;
    bit    started = 0;
    bit    done = 0;
    int    checks = 0;
    int    errors = 0;

    function automatic slot_t mk(input logic [3:0] c, input logic [11:0] a, input string t);
        slot_t s;
        s.cmd = c; s.addr = a; s.tag = t;
        return s;
    endfunction

    task automatic push_nops(input int n, input string t);
        for (int i = 0; i < n; i++) q.push_back(mk(K_NOP, 12'h000, t));
    endtask

    task automatic build_init();
        q.delete();
        push_nops(PWRUP, "R2");
        q.push_back(mk(K_PRE, 12'h400, "R5"));
        push_nops(TRP - 1, "R3");
        for (int r = 0; r < NREF; r++) begin
            q.push_back(mk(K_REF, 12'h000, "R3"));
            push_nops(TRC - 1, "R3");
        end
        q.push_back(mk(K_MRS, MODE, "R3"));
        push_nops(TMRD - 1, "R4");
    endtask

    // Behavioural reference model, advanced at each rising edge
    always @(posedge clk) begin
        bit idle_end, tick, take;
        started <= 1'b1;
        if (!rst_n) begin
            build_init();
            owed  = 0;
            since = 0;
            rdy   = 0;
        end else begin
            idle_end = rdy && (q.size() == 0);
            tick = 0;
            if (rdy) begin
                since++;
                if (since == REFI) begin since = 0; tick = 1; end
            end
            take = idle_end && (owed > 0) && grant_i;
            if (q.size() > 0) void'(q.pop_front());
            if (take) begin
                if (bank_open_i) begin
                    q.push_back(mk(K_PRE, 12'h400, "R8"));
                    push_nops(TRP - 1, "R8");
                end
                q.push_back(mk(K_REF, 12'h000, "R8"));
                push_nops(TRC - 1, "R9");
            end
            owed = owed + int'(tick) - int'(take);
            if (owed > MAXO) owed = MAXO;
            if (q.size() == 0) rdy = 1;
        end
    end

    task automatic chk(input bit ok, input string tag, input string what, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s act=%0h exp=%0h at %0t", tag, what, act, exp, $time);
        end
    endtask

    // Compare on every falling edge
    always @(negedge clk) begin
        if (started && !done) begin
            logic [3:0]  ec;
            logic [11:0] ea;
            string       t;
            bit          er, eu, eb;
            if (q.size() > 0) begin
                ec = q[0].cmd; ea = q[0].addr; t = q[0].tag;
            end else begin
                ec = K_NOP; ea = 12'h000;
                t  = (owed > 0 && !grant_i) ? "R7" : "R11";
            end
            er = rdy && (q.size() == 0) && (owed > 0);
            eu = er && (owed == MAXO);
            eb = (q.size() > 0) || !rdy;
            if (!rst_n) t = "R1";
            chk(cmd_o == ec, t, "cmd", int'(cmd_o), int'(ec));
            chk(addr_o == ea && ba_o == 2'b00, t, "addr/ba", int'({ba_o, addr_o}), int'(ea));
            chk(ready_o == rdy, rst_n ? "R4" : "R1", "ready", int'(ready_o), int'(rdy));
            chk(req_o == er, rst_n ? ((er && !grant_i) ? "R7" : "R6") : "R1", "req", int'(req_o), int'(er));
            chk(urgent_o == eu, rst_n ? "R10" : "R1", "urgent", int'(urgent_o), int'(eu));
            chk(busy_o == eb, rst_n ? "R9" : "R1", "busy", int'(busy_o), int'(eb));
        end
    end

    task automatic summary();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
    endtask

    task automatic drive(input bit g, input bit b, input int n);
        @(posedge clk); #3;
        grant_i = g; bank_open_i = b;
        repeat (n - 1) @(posedge clk);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #3 rst_n = 1'b1;
        // R2 R3 R4: start-up with grant low
        drive(1'b0, 1'b0, 100);
        // R6 R8 R11: granted refreshes with closed banks
        drive(1'b1, 1'b0, 130);
        // R8: granted refreshes with an open bank
        drive(1'b1, 1'b1, 130);
        // R7 R10: deferral past the limit
        drive(1'b0, 1'b0, 220);
        // R10: drain with alternating bank state
        for (int k = 0; k < 10; k++) drive(1'b1, k[0], 13);
        drive(1'b1, 1'b0, 60);
        @(negedge clk);
        done = 1;
        summary();
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1;
            errors++;
            $display("FAIL watchdog expired");
            summary();
            $finish;
        end
    end

endmodule